// File: doc/BRIEF.md
# Command-Framed Serial Register Port

This block is the slave side of a serial link through which a host reads and writes a small set of registers. The host drives a serial clock, a data input and an active-low select. The block returns data on a serial output with an output enable, and it drives an active-low ready line. Every access has two steps. First the host sends one byte to the command register. That byte names the direction and the target register. Then exactly one data word moves in that direction, and the port goes back to waiting for a command. The block samples every serial input with its own system clock, so the serial clock must run well below that clock.

Two converter channels hand finished words to the block as parallel values with an update strobe. The block shows the word to the host only after a short hide window, so that the ready line drops before the data register changes. The ready line is the NOR of the per-channel ready bits of the enabled channels, together with a calibration-done hold. A host that has lost framing can recover without a reset pin by holding the data input at one for 32 serial clocks.

Top module: `cmd_serial_port`

## Requirements
- R1: After reset, the port expects a command byte. The ready output is 1, the output enable is 0, the mode register reads 0x03 and the scratch register reads 0x00.
- R2: A command byte is sent MSB first. Bit 6 set to 1 means read and 0 means write. Bits 2:0 give the address: 1 status (read only), 2 mode, 3 scratch, 4 channel-A data, 5 channel-B data. Exactly one data word follows, and the port then expects a command again.
- R3: DIN is sampled on the rising SCLK edge and DOUT changes on the falling edge, MSB first. The status, mode and scratch words are 8 bits, channel-A data is AW=24 bits and channel-B data is BW=16 bits.
- R4: When DIN has been 1 for 32 consecutive rising SCLK edges, every register returns to its reset value and the port expects a command, even in the middle of a word.
- R5: While the select is high, the output enable is 0 and any partly shifted word is thrown away, so the next frame starts with a command byte.
- R6: Status bit 0 is the channel-A ready bit, bit 1 is the channel-B ready bit and bit 2 is the calibration hold. Mode bit 0 enables channel A and mode bit 1 enables channel B. The ready output is low exactly when an enabled channel is ready or the calibration hold is set.
- R7: Completing a read of a channel's data register clears that channel's ready bit. A second read returns the same word.
- R8: An update strobe clears the channel's ready bit at the next clock. The data register keeps its old value for HIDE_CYC=4 cycles, then takes the new word and sets the ready bit.
- R9: A calibration-done pulse sets the calibration hold. The hold stays set, and status reads do not clear it, until the mode register is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low select and frame marker |
| din | input | 1 | Serial data from the host |
| dout | output | 1 | Serial data to the host |
| dout_oe | output | 1 | Enable for the DOUT driver |
| rdy_n | output | 1 | Active-low aggregated ready |
| upd_a | input | 1 | Channel-A word strobe |
| word_a | input | AW | Channel-A word |
| upd_b | input | 1 | Channel-B word strobe |
| word_b | input | BW | Channel-B word |
| cal_done | input | 1 | Calibration-complete pulse |

## Verification
A wrong phase or bit count inside the port shows up first as a mis-framed access. The host then reads a value shifted by some bits, or a write lands in the wrong register, and the readback after the very next command exposes it. Errors in a ready bit show on rdy_n within one system clock of the strobe, read or mode write that caused them. Errors in the hide window show as rdy_n going low before HIDE_CYC cycles have passed, or as stale data in the first read after it goes low.

// File: rtl/cmd_serial_port.sv
module cmd_serial_port #(
  parameter int AW = 24,
  parameter int BW = 16,
  parameter int HIDE_CYC = 4,
  parameter int ONES_LIMIT = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sclk,
  input  logic          cs_n,
  input  logic          din,
  output logic          dout,
  output logic          dout_oe,
  output logic          rdy_n,
  input  logic          upd_a,
  input  logic [AW-1:0] word_a,
  input  logic          upd_b,
  input  logic [BW-1:0] word_b,
  input  logic          cal_done
);
  localparam int SW = AW;
  localparam int CW = $clog2(SW + 1);
  localparam int HW = $clog2(HIDE_CYC + 1);
  localparam int OW = $clog2(ONES_LIMIT);
  localparam logic [7:0] MODE_RST = 8'h03;

  typedef enum logic [1:0] {PH_CMD, PH_WR, PH_RD} ph_t;

  ph_t           ph;
  logic          sclk_q, ld_pend, cal_hold, rdy_a, rdy_b;
  logic [SW-1:0] sin, sout, rd_word;
  logic [CW-1:0] cnt, cmd_len;
  logic [2:0]    addr;
  logic [OW-1:0] ones;
  logic [7:0]    mode, scratch, cmd_next;
  logic [AW-1:0] dreg_a, stage_a;
  logic [BW-1:0] dreg_b, stage_b;
  logic [HW-1:0] hid_a, hid_b;

  wire rise    = sclk & ~sclk_q & ~cs_n;
  wire fall    = ~sclk & sclk_q & ~cs_n;
  wire srst    = rise & din & (ones == OW'(ONES_LIMIT - 1));
  wire wr_done = rise && ph == PH_WR && cnt == '0;
  wire rd_done = rise && ph == PH_RD && cnt == '0;

  assign cmd_next = {sin[6:0], din};
  assign dout     = sout[SW-1];
  assign dout_oe  = ~cs_n;
  assign rdy_n    = ~((rdy_a & mode[0]) | (rdy_b & mode[1]) | cal_hold);

  always_comb begin
    case (cmd_next[2:0])
      3'd4:    cmd_len = CW'(AW - 1);
      3'd5:    cmd_len = CW'(BW - 1);
      default: cmd_len = CW'(7);
    endcase
    rd_word = '0;
    case (addr)
      3'd1: rd_word[SW-1 -: 8] = {5'b0, cal_hold, rdy_b, rdy_a};
      3'd2: rd_word[SW-1 -: 8] = mode;
      3'd3: rd_word[SW-1 -: 8] = scratch;
      3'd4: rd_word[SW-1 -: AW] = dreg_a;
      3'd5: rd_word[SW-1 -: BW] = dreg_b;
      default: rd_word = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_q <= 1'b1;
    else        sclk_q <= sclk;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= PH_CMD; cnt <= CW'(7); sin <= '0; sout <= '0;
      addr <= '0; ld_pend <= 1'b0; ones <= '0;
    end else if (srst || cs_n) begin
      ph <= PH_CMD; cnt <= CW'(7); ld_pend <= 1'b0; ones <= '0;
    end else begin
      if (rise) begin
        ones <= din ? ones + 1'b1 : '0;
        sin  <= {sin[SW-2:0], din};
        if (cnt == '0) begin
          if (ph == PH_CMD) begin
            addr    <= cmd_next[2:0];
            cnt     <= cmd_len;
            ph      <= cmd_next[6] ? PH_RD : PH_WR;
            ld_pend <= cmd_next[6];
          end else begin
            ph  <= PH_CMD;
            cnt <= CW'(7);
          end
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
      if (fall && ph == PH_RD) begin
        sout    <= ld_pend ? rd_word : {sout[SW-2:0], 1'b0};
        ld_pend <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= MODE_RST; scratch <= '0; cal_hold <= 1'b0;
      rdy_a <= 1'b0; rdy_b <= 1'b0; dreg_a <= '0; dreg_b <= '0;
      stage_a <= '0; stage_b <= '0; hid_a <= '0; hid_b <= '0;
    end else if (srst) begin
      mode <= MODE_RST; scratch <= '0; cal_hold <= 1'b0;
      rdy_a <= 1'b0; rdy_b <= 1'b0; dreg_a <= '0; dreg_b <= '0;
      stage_a <= '0; stage_b <= '0; hid_a <= '0; hid_b <= '0;
    end else begin
      if (wr_done && addr == 3'd2) begin
        mode <= cmd_next; cal_hold <= 1'b0;
      end
      if (wr_done && addr == 3'd3) scratch <= cmd_next;
      if (cal_done) cal_hold <= 1'b1;

      if (upd_a) begin
        stage_a <= word_a; hid_a <= HW'(HIDE_CYC); rdy_a <= 1'b0;
      end else if (hid_a != '0) begin
        hid_a <= hid_a - 1'b1;
        if (hid_a == HW'(1)) begin dreg_a <= stage_a; rdy_a <= 1'b1; end
      end else if (rd_done && addr == 3'd4) rdy_a <= 1'b0;

      if (upd_b) begin
        stage_b <= word_b; hid_b <= HW'(HIDE_CYC); rdy_b <= 1'b0;
      end else if (hid_b != '0) begin
        hid_b <= hid_b - 1'b1;
        if (hid_b == HW'(1)) begin dreg_b <= stage_b; rdy_b <= 1'b1; end
      end else if (rd_done && addr == 3'd5) rdy_b <= 1'b0;
    end
  end

  assert_hide_before_update_R8: assert property (@(posedge clk) disable iff (!rst_n)
    upd_a |=> !rdy_a);
  assert_ready_after_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy_a) |-> $past(hid_a) == HW'(1));
  assert_select_drops_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> ph == PH_CMD);
  assert_resync_restores_R4: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (ph == PH_CMD && mode == MODE_RST && !rdy_a && !rdy_b && !cal_hold));
  assert_cal_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_done && addr == 3'd2 && !cal_done) |=> !cal_hold);
  assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_done && addr == 3'd4 && !upd_a && hid_a == '0) |=> !rdy_a);
endmodule

// File: tb/cmd_serial_port_bench.sv
module cmd_serial_port_bench;
  logic clk = 0, rst_n = 0, sclk = 1, cs_n = 1, din = 1;
  logic upd_a = 0, upd_b = 0, cal_done = 0;
  logic [23:0] word_a = '0;
  logic [15:0] word_b = '0;
  logic dout, dout_oe, rdy_n;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cmd_serial_port u_cmd_serial_port (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .din(din),
    .dout(dout), .dout_oe(dout_oe), .rdy_n(rdy_n),
    .upd_a(upd_a), .word_a(word_a), .upd_b(upd_b), .word_b(word_b),
    .cal_done(cal_done));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic xfer(int n, logic [31:0] wd, output logic [31:0] rd);
    rd = '0;
    for (int i = n - 1; i >= 0; i--) begin
      @(negedge clk); sclk = 0; din = wd[i];
      repeat (3) @(negedge clk);
      rd = {rd[30:0], dout};
      sclk = 1;
      repeat (4) @(negedge clk);
    end
    din = 1;
  endtask

  task automatic access(logic [7:0] cmd, int n, logic [31:0] wd, output logic [31:0] rd);
    logic [31:0] junk;
    xfer(8, {24'b0, cmd}, junk);
    xfer(n, wd, rd);
  endtask

  task automatic test_reset;
    logic [31:0] r;
    check("R1 rdy_n after reset", rdy_n, 1);
    check("R1 dout_oe after reset", dout_oe, 0);
    @(negedge clk); cs_n = 0;
    access(8'h42, 8, 0, r); check("R1 mode reset value", r, 32'h03);
    access(8'h43, 8, 0, r); check("R1 scratch reset value", r, 32'h00);
  endtask

  task automatic test_scratch;
    logic [31:0] r;
    access(8'h03, 8, 32'hA5, r);
    access(8'h43, 8, 0, r); check("R2 scratch write/read", r, 32'hA5);
    access(8'h03, 8, 32'h3C, r);
    access(8'h43, 8, 0, r); check("R2 back-to-back command", r, 32'h3C);
  endtask

  task automatic test_chan_a;
    logic [31:0] r;
    @(negedge clk); upd_a = 1; word_a = 24'h123456;
    @(negedge clk); upd_a = 0;
    repeat (10) @(negedge clk);
    check("R6 rdy_n low on new A word", rdy_n, 0);
    access(8'h41, 8, 0, r); check("R6 status bit0 set", r, 32'h01);
    access(8'h44, 24, 0, r); check("R3 24-bit A read MSB first", r, 32'h123456);
    check("R7 rdy_n high after read", rdy_n, 1);
    access(8'h44, 24, 0, r); check("R7 reread same word", r, 32'h123456);
    access(8'h41, 8, 0, r); check("R7 status bit0 clear", r, 32'h00);
  endtask

  task automatic test_hide;
    logic [31:0] r;
    @(negedge clk); upd_a = 1; word_a = 24'h0000AA;
    @(negedge clk); upd_a = 0;
    repeat (10) @(negedge clk);
    check("R8 ready before second update", rdy_n, 0);
    @(negedge clk); upd_a = 1; word_a = 24'hFEDCBA;
    @(negedge clk); upd_a = 0;
    check("R8 ready drops at strobe", rdy_n, 1);
    @(negedge clk);
    check("R8 ready hidden during window", rdy_n, 1);
    repeat (6) @(negedge clk);
    check("R8 ready returns after window", rdy_n, 0);
    access(8'h44, 24, 0, r); check("R8 new word loaded", r, 32'hFEDCBA);
  endtask

  task automatic test_chan_b;
    logic [31:0] r;
    access(8'h02, 8, 32'h02, r);
    @(negedge clk); upd_a = 1; word_a = 24'h000111;
    @(negedge clk); upd_a = 0;
    repeat (10) @(negedge clk);
    check("R6 disabled A hidden from rdy_n", rdy_n, 1);
    access(8'h41, 8, 0, r); check("R6 status shows A ready", r, 32'h01);
    @(negedge clk); upd_b = 1; word_b = 16'hBEEF;
    @(negedge clk); upd_b = 0;
    repeat (10) @(negedge clk);
    check("R6 enabled B drives rdy_n", rdy_n, 0);
    access(8'h45, 16, 0, r); check("R3 16-bit B read", r, 32'hBEEF);
    check("R7 rdy_n high after B read", rdy_n, 1);
    access(8'h44, 24, 0, r); check("R7 A data via read", r, 32'h000111);
    access(8'h41, 8, 0, r); check("R7 status clear", r, 32'h00);
  endtask

  task automatic test_cal;
    logic [31:0] r;
    @(negedge clk); cal_done = 1;
    @(negedge clk); cal_done = 0;
    check("R9 cal hold drives rdy_n", rdy_n, 0);
    access(8'h41, 8, 0, r); check("R9 status cal bit", r, 32'h04);
    check("R9 status read keeps hold", rdy_n, 0);
    access(8'h02, 8, 32'h03, r);
    check("R9 mode write releases hold", rdy_n, 1);
  endtask

  task automatic test_select;
    logic [31:0] r;
    xfer(4, 32'h0, r);
    @(negedge clk); cs_n = 1;
    repeat (2) @(negedge clk);
    check("R5 oe low while deselected", dout_oe, 0);
    cs_n = 0;
    @(negedge clk);
    check("R5 oe high when selected", dout_oe, 1);
    access(8'h43, 8, 0, r); check("R5 partial word discarded", r, 32'h3C);
  endtask

  task automatic test_resync;
    logic [31:0] r;
    access(8'h02, 8, 32'h01, r);
    xfer(8, 32'h03, r);
    xfer(3, 32'h2, r);
    xfer(32, 32'hFFFFFFFF, r);
    access(8'h43, 8, 0, r); check("R4 scratch reset by ones", r, 32'h00);
    access(8'h42, 8, 0, r); check("R4 mode reset by ones", r, 32'h03);
    access(8'h44, 24, 0, r); check("R4 A data reset by ones", r, 32'h0);
    check("R4 rdy_n idle after resync", rdy_n, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    test_reset();
    test_scratch();
    test_chan_a();
    test_hide();
    test_chan_b();
    test_cal();
    test_select();
    test_resync();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule